// File: doc/BRIEF.md
# Fixed-Direction GPIO Port with Edge Interrupts

This block is an eight-pin general-purpose I/O port seen by software as a small bank of byte-wide registers. The four low pins are permanently outputs and the four high pins are permanently inputs. Software drives the outputs and samples the inputs through one data register. It can ask each input to flag a rising edge, a falling edge or both. Flagged edges are held in a sticky status register, and a single registered interrupt line stays high while any flag is held.

Each input first passes through a two-flop synchroniser. Edge detection compares the synchronised level with its value one cycle earlier. A qualifying edge sets its status flag in the cycle after the edge is seen, but only if the matching enable bit is set in that cycle. Software clears a flag by writing a 1 to it, and a fresh edge in the same cycle as the clear keeps the flag set. The register bus is a plain synchronous strobe interface with no back-pressure. A write is taken on the clock edge where `bus_en` and `bus_we` are both high. Read data is combinational and valid while `bus_en` is high and `bus_we` is low, and it is zero otherwise.

Top module: `gpio_edge_port`

## Requirements
- R1: The direction register at offset 0 always reads 0x0F (bit n = 1 marks pin n as an output), and writes to it have no effect. `pin_dir` shows the same mask.
- R2: A write to offset 1 loads bits [3:0] of the write data onto `pin_out[3:0]` at the next clock edge. Bits [7:4] of that write are ignored.
- R3: A read of offset 1 returns the output values in bits [3:0] and the synchronised input levels in bits [7:4]. An input change becomes visible after exactly two clock edges.
- R4: Offset 3 is a read/write configuration register. Input k (pin k+4) owns bits [2k+1:2k]: the low bit of that field enables falling edges and the high bit enables rising edges.
- R5: With its rising enable set, a rising edge on an input sets status bit k at offset 4. A rising edge with only the falling enable set does not set it.
- R6: With its falling enable set, a falling edge sets status bit k. A field value of 3 catches both edges, and a field value of 0 catches neither.
- R7: Status bits are sticky. Writing 1 to a bit at offset 4 clears it, and writing 0 leaves it unchanged.
- R8: If a qualifying edge sets a status bit in the same cycle that a write clears that bit, the bit stays set.
- R9: `irq` is the OR of the status bits, registered, so it follows the status register one clock later.
- R10: Reads of offsets 2, 5, 6 and 7 return 0, and writes to them change no register and no pin.
- R11: After reset, `pin_out`, the configuration register, the status register and `irq` are all 0, and the direction register reads 0x0F.
- R12: A status bit never becomes set without a qualifying, enabled edge on its input in the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| pin_in | input | 4 | Input pins 4..7 (asynchronous) |
| pin_out | output | 4 | Output pins 0..3 |
| pin_dir | output | 8 | Direction indication, 1 = output |
| irq | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
The bench walks every pairing of edge direction and enable field, including the masked field and the field that enables only the opposite edge. A design with the two enable bits swapped, or with the field shift off by one, flags the wrong pin or flags the wrong edge.

It lines up a write-1 clear with the exact cycle in which a new edge lands. A design that lets the clear win loses that interrupt.

It reads the data register one cycle before and one cycle after an input change is due to appear. This exposes a synchroniser that is too short or too long. It also watches `irq` fall one cycle after the status clear, which shows whether the interrupt line is registered.

Writes of all ones to the unmapped offsets and to the direction register are followed by a read-back of every register and a check of the pins. A decoder that aliases those offsets then shows up as a changed register or pin.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] OFS_DIR  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;
  // position of each enable inside a per-input trigger field
  localparam int TRIG_FALL = 0;
  localparam int TRIG_RISE = 1;
  localparam int TRIG_W    = 2;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
  import gpio_edge_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int CFG_W = N_IN * TRIG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  level,
  input  logic [CFG_W-1:0] cfg,
  output logic [N_IN-1:0]  hit
);
  logic [N_IN-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level;
  end

  for (genvar k = 0; k < N_IN; k++) begin : g_edge
    logic rise, fall;
    assign rise   = level[k] & ~prev_q[k];
    assign fall   = ~level[k] & prev_q[k];
    assign hit[k] = (rise & cfg[TRIG_W*k + TRIG_RISE]) |
                    (fall & cfg[TRIG_W*k + TRIG_FALL]);
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int N_IN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] hit,
  input  logic [N_IN-1:0] clr,
  output logic [N_IN-1:0] stat,
  output logic            irq
);
  logic [N_IN-1:0] stat_q;
  logic            irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | hit;
      irq_q  <= |stat_q;
    end
  end

  assign stat = stat_q;
  assign irq  = irq_q;

  // R9: interrupt line tracks status one cycle later
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == $past(|stat_q));

  for (genvar k = 0; k < N_IN; k++) begin : g_chk
    // R8: an edge arriving together with a clear keeps the flag
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> stat_q[k]);
    // R7: a held flag without a clear stays held
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[k] && !clr[k]) |=> stat_q[k]);
    // R12: no flag rises without an enabled edge
    a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[k] && !hit[k]) |=> !stat_q[k]);
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_IN  = 4,
  localparam int DATA_W = N_OUT + N_IN,
  localparam int CFG_W  = N_IN * TRIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_IN-1:0]   in_level,
  input  logic [N_IN-1:0]   stat,
  output logic [N_OUT-1:0]  out_q,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [N_IN-1:0]   clr,
  output logic [DATA_W-1:0] dir_mask
);
  localparam logic [DATA_W-1:0] DIR_MASK = DATA_W'({N_OUT{1'b1}});

  logic wr, rd;
  assign wr = bus_en & bus_we;
  assign rd = bus_en & ~bus_we;
  assign dir_mask = DIR_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      cfg_q <= '0;
    end else if (wr) begin
      if (bus_addr == OFS_DATA) out_q <= bus_wdata[N_OUT-1:0];
      if (bus_addr == OFS_CFG)  cfg_q <= bus_wdata[CFG_W-1:0];
    end
  end

  assign clr = (wr && bus_addr == OFS_STAT) ? bus_wdata[N_IN-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        OFS_DIR:  bus_rdata = DIR_MASK;
        OFS_DATA: bus_rdata = {in_level, out_q};
        OFS_CFG:  bus_rdata = DATA_W'(cfg_q);
        OFS_STAT: bus_rdata = DATA_W'(stat);
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R2: a data write lands on the outputs one edge later
  a_r2_out_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == OFS_DATA) |=> out_q == $past(bus_wdata[N_OUT-1:0]));
  // R10: writes elsewhere leave outputs and configuration untouched
  a_r10_no_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr != OFS_DATA && bus_addr != OFS_CFG) |=> ($stable(out_q) && $stable(cfg_q)));
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int N_OUT       = 4,
  parameter int N_IN        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W = N_OUT + N_IN,
  localparam int CFG_W  = N_IN * TRIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_IN-1:0]   pin_in,
  output logic [N_OUT-1:0]  pin_out,
  output logic [DATA_W-1:0] pin_dir,
  output logic              irq
);
  logic [N_IN-1:0]  level, hit, clr, stat;
  logic [CFG_W-1:0] cfg;

  initial begin
    a_cfg_fits: assert (CFG_W <= DATA_W);
  end

  gpio_in_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(level));

  gpio_edge_detect #(.N_IN(N_IN)) u_edge (
    .clk(clk), .rst_n(rst_n), .level(level), .cfg(cfg), .hit(hit));

  gpio_irq_status #(.N_IN(N_IN)) u_stat (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .stat(stat), .irq(irq));

  gpio_regs #(.N_OUT(N_OUT), .N_IN(N_IN)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .in_level(level), .stat(stat), .out_q(pin_out), .cfg_q(cfg),
    .clr(clr), .dir_mask(pin_dir));
endmodule

// File: tb/gpio_edge_port_bench.sv
module gpio_edge_port_bench;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_we = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [3:0] pin_in = '0, pin_out;
  logic [7:0] pin_dir;
  logic irq;
  int n_chk = 0, n_fail = 0;
  logic [7:0] v;

  always #2 clk = ~clk;

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_dir(pin_dir), .irq(irq));

  // {input index[1:0], field[1:0], rising, expect flag}
  localparam logic [5:0] VEC [8] = '{
    {2'd0, 2'b01, 1'b1, 1'b0}, {2'd0, 2'b01, 1'b0, 1'b1},
    {2'd1, 2'b10, 1'b1, 1'b1}, {2'd1, 2'b10, 1'b0, 1'b0},
    {2'd2, 2'b11, 1'b1, 1'b1}, {2'd3, 2'b11, 1'b0, 1'b1},
    {2'd2, 2'b00, 1'b1, 1'b0}, {2'd3, 2'b00, 1'b0, 1'b0}};

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd_now(logic [2:0] a, output logic [7:0] d);
    bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1;
    // R11 reset values
    rd(3'd0, v); chk("R11 dir", v, 8'h0F);
    rd(3'd1, v); chk("R11 data", v, 8'h00);
    rd(3'd3, v); chk("R11 cfg", v, 8'h00);
    rd(3'd4, v); chk("R11 stat", v, 8'h00);
    chk("R11 irq", {7'd0, irq}, 8'h00);

    // table walk: R4 R5 R6 R12
    foreach (VEC[i]) begin
      logic [1:0] k; logic [1:0] f; logic r, e;
      {k, f, r, e} = VEC[i];
      wr(3'd3, 8'h00);
      pin_in[k] = ~r;
      cycles(4);
      wr(3'd4, 8'hFF);
      wr(3'd3, 8'(f) << (2 * k));
      rd(3'd3, v); chk("R4 cfg readback", v, 8'(f) << (2 * k));
      @(negedge clk); pin_in[k] = r;
      cycles(4);
      rd(3'd4, v);
      chk(r ? "R5 rising flag" : "R6 falling flag", v, 8'(e) << k);
      chk("R9 irq with flag", {7'd0, irq}, {7'd0, e});
      chk("R12 stays clear", v & ~(8'(1) << k), 8'h00);
      wr(3'd4, 8'hFF);
    end
    wr(3'd3, 8'h00);
    pin_in = '0;
    cycles(4);
    wr(3'd4, 8'hFF);
    cycles(2);

    // R2 output writes
    wr(3'd1, 8'hA5);
    chk("R2 pin_out", {4'd0, pin_out}, 8'h05);
    rd(3'd1, v); chk("R2 upper ignored", v, 8'h05);

    // R3 two-edge input latency
    @(negedge clk); pin_in = 4'hC;
    @(negedge clk); rd_now(3'd1, v); chk("R3 not yet", v, 8'h05);
    @(negedge clk); rd_now(3'd1, v); chk("R3 visible", v, 8'hC5);

    // R7 sticky, write 0 no effect, write 1 clears; R9 lag
    wr(3'd3, 8'h03);
    @(negedge clk); pin_in[0] = 1'b1;
    cycles(4);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R7 write0 keeps", v, 8'h01);
    wr(3'd4, 8'h01);
    rd_now(3'd4, v); chk("R7 cleared", v, 8'h00);
    chk("R9 irq lags one", {7'd0, irq}, 8'h01);
    @(negedge clk); chk("R9 irq falls", {7'd0, irq}, 8'h00);

    // R8 set wins over simultaneous clear
    @(negedge clk); pin_in[0] = 1'b0;
    cycles(4);
    rd(3'd4, v); chk("R8 prior flag", v, 8'h01);
    @(negedge clk); pin_in[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R8 edge beats clear", v, 8'h01);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R8 later clear", v, 8'h00);

    // R10 and R1: writes to unmapped offsets and direction are ignored
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd0, v); chk("R1 dir fixed", v, 8'h0F);
    chk("R1 pin_dir", pin_dir, 8'h0F);
    rd(3'd1, v); chk("R10 data kept", v, 8'hD5);
    rd(3'd3, v); chk("R10 cfg kept", v, 8'h03);
    rd(3'd4, v); chk("R10 stat kept", v, 8'h00);
    chk("R10 pins kept", {4'd0, pin_out}, 8'h05);
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v); chk("R10 unmapped read", v, 8'h00);
    end
    rd(3'd2, v); chk("R10 offset2 read", v, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule